// File: doc/BRIEF.md
# Two-Wide Execute Dispatcher with Multi-Cycle Units

This block is the execute stage of an in-order processor that moves two instructions per cycle. Upstream offers a pair (older in lane 0, younger in lane 1). Each instruction carries a one-bit operation class (subtract or not) and a tag. The pair is held in a decode register inside the block. From there each instruction is sent to a free functional unit of the right kind. There are three such units: one subtracter that takes three cycles and two adders that take two cycles. None of the units is pipelined.

An instruction whose unit is busy stays in the decode register, and `in_ready` drops so that upstream holds its next pair. Issue keeps program order: a younger instruction never enters a unit ahead of an older one. When units finish, their tags appear on up to three output lanes. The lanes are packed from lane 0 and ordered oldest first, each with its own valid bit. The arithmetic, operand forwarding and hazard checks are not part of this block.

Top module: `ex_dispatch`

## Requirements
- R1: One rising edge with `rst_n` low leaves `in_ready` at 1 and `out_valid` at 0. No instruction accepted or issued before that edge ever produces a completion.
- R2: `in_valid[0]` marks the older instruction and `in_valid[1]` the younger. `in_valid[1]` is set only together with `in_valid[0]`. `in_sub` bit k = 1 marks lane k as a subtraction, and 0 marks any other operation.
- R3: A non-subtract instruction goes to an adder. If it is offered in cycle n with `in_ready` high and an adder is free, its tag appears on an output lane in cycle n+3.
- R4: A subtraction goes only to the subtracter. If it is offered in cycle n with `in_ready` high and the subtracter is free, its tag appears in cycle n+4.
- R5: A unit holds one instruction at a time. It accepts new work only in a cycle after its completion cycle. Two paired subtractions offered in cycle n complete in cycles n+4 and n+8. Two add pairs offered in cycles n and n+1 complete in cycles n+3 and n+6.
- R6: While a held instruction cannot issue, it stays in the decode register unchanged and `in_ready` is 0. `in_ready` returns to 1 in the cycle in which every held instruction issues.
- R7: The younger instruction never issues before the older one. If a lone subtraction is offered in cycle n and a pair (subtraction, add) is offered in cycle n+1, the add waits for the subtraction ahead of it. The completions fall in cycles n+4, n+7 and n+8.
- R8: If both instructions of a pair are adds and both adders are free, both issue together and complete in the same cycle. The older tag is on lane 0.
- R9: Completions in the same cycle fill lanes from lane 0 with no gaps, oldest first. A lone subtraction offered in cycle n, followed by an add pair in cycle n+1, gives three valid lanes in cycle n+4, ordered subtraction, older add, younger add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 2 | Offered instructions; bit 0 older, bit 1 younger |
| in_sub | input | 2 | Per lane: 1 = subtraction, 0 = other operation |
| in_tag0 | input | TAG_W | Tag of the older offered instruction |
| in_tag1 | input | TAG_W | Tag of the younger offered instruction |
| in_ready | output | 1 | Offered pair is taken at this clock edge |
| out_valid | output | 3 | Completion lanes, packed from bit 0 |
| out_tag0 | output | TAG_W | Oldest completing tag this cycle |
| out_tag1 | output | TAG_W | Second completing tag |
| out_tag2 | output | TAG_W | Third completing tag |

## Verification
Two things can happen in the same cycle: the subtracter finishing, and both adders finishing. The bench provokes this with a lone subtraction followed one cycle later by an add pair, so all three results land in one cycle. It judges the outcome by the exact completion cycle and by the lane order of the three tags. Issue into a freed unit can also coincide with the reporting of the job that freed it. Back-to-back subtractions and add pairs show that a new job starts only after the old result has been reported.

// File: rtl/exd_pkg.sv
// Shared definitions for the two-wide execute dispatcher.
// Assumes unit index 0 is the subtracter and indices 1 and 2 are adders;
// the completion ordering relies on that index order.
package exd_pkg;
    localparam int NUM_UNITS = 3;

    typedef enum logic [1:0] {
        UNIT_SUB  = 2'd0,
        UNIT_ADD0 = 2'd1,
        UNIT_ADD1 = 2'd2,
        UNIT_NONE = 2'd3
    } unit_e;
endpackage

// File: rtl/exd_issue.sv
// Issue selection for the two decode slots.
// Picks a unit for the older slot, then for the younger one from what is
// left, and never lets the younger go without the older.
// Assumes slot 1 is valid only when slot 0 is valid.
module exd_issue
    import exd_pkg::*;
(
    input  logic [1:0] slot_vld,
    input  logic [1:0] slot_sub,
    input  logic [2:0] unit_free,
    output logic       go0,
    output logic       go1,
    output unit_e      dst0,
    output unit_e      dst1
);
    // Chooses the unit for one instruction given the set of free units.
    function automatic unit_e pick(input logic is_sub, input logic [2:0] avail);
        if (is_sub)        return avail[0] ? UNIT_SUB : UNIT_NONE;
        else if (avail[1]) return UNIT_ADD0;
        else if (avail[2]) return UNIT_ADD1;
        else               return UNIT_NONE;
    endfunction

    // Returns the one-hot mask of a unit.
    function automatic logic [2:0] mask_of(input unit_e u);
        case (u)
            UNIT_SUB:  return 3'b001;
            UNIT_ADD0: return 3'b010;
            UNIT_ADD1: return 3'b100;
            default:   return 3'b000;
        endcase
    endfunction

    logic [2:0] left_free;

    // In-order pick: the older takes first, the younger uses what remains.
    always_comb begin
        dst0      = pick(slot_sub[0], unit_free);
        go0       = slot_vld[0] && (dst0 != UNIT_NONE);
        left_free = unit_free & ~(go0 ? mask_of(dst0) : 3'b000);
        dst1      = pick(slot_sub[1], left_free);
        go1       = go0 && slot_vld[1] && (dst1 != UNIT_NONE);
    end
endmodule

// File: rtl/exd_unit.sv
// One non-pipelined functional unit modelled as a busy counter.
// Loading sets the counter to LAT, and it counts down to zero. The unit is
// free only at zero and reports completion while the count is one.
// Assumes start is raised only while the unit is free.
module exd_unit #(
    parameter int LAT   = 2,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TAG_W-1:0] start_tag,
    output logic             free,
    output logic             done,
    output logic [TAG_W-1:0] tag
);
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt;

    // Busy counter: load on start, count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(LAT);
        else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
    end

    // Tag of the job in flight, captured on start.
    always_ff @(posedge clk) begin
        if (!rst_n)     tag <= '0;
        else if (start) tag <= start_tag;
    end

    assign free = (cnt == '0);
    assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/exd_order.sv
// Packs unit completions onto output lanes from lane 0, oldest first.
// Assumes the input index order is the age order among simultaneous
// completions: the subtracter (longer latency, so issued earlier), then
// adder 0 (given to the older of a pair), then adder 1.
module exd_order #(
    parameter int NUM   = 3,
    parameter int TAG_W = 4
) (
    input  logic [NUM-1:0]   done,
    input  logic [TAG_W-1:0] tag_in  [NUM],
    output logic [NUM-1:0]   vld_out,
    output logic [TAG_W-1:0] tag_out [NUM]
);
    localparam int RW = $clog2(NUM + 1);

    // Walks the units in age order and assigns each completion the next lane.
    always_comb begin
        logic [RW-1:0] lane;
        lane = '0;
        for (int k = 0; k < NUM; k++) begin
            vld_out[k] = 1'b0;
            tag_out[k] = '0;
        end
        for (int i = 0; i < NUM; i++) begin
            if (done[i]) begin
                for (int k = 0; k < NUM; k++) begin
                    if (lane == RW'(k)) begin
                        vld_out[k] = 1'b1;
                        tag_out[k] = tag_in[i];
                    end
                end
                lane = lane + RW'(1);
            end
        end
    end
endmodule

// File: rtl/ex_dispatch.sv
// Two-wide in-order execute dispatcher with one subtracter and two adders.
// Holds the offered pair in a decode register, issues in program order to
// free units, and reports completions on packed, age-ordered lanes.
// Assumes SUB_LAT > ADD_LAT, so the lane ordering in exd_order holds, and
// assumes upstream keeps a pair stable until in_ready is seen high.
module ex_dispatch
    import exd_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int ADD_LAT = 2,
    parameter int SUB_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       in_valid,
    input  logic [1:0]       in_sub,
    input  logic [TAG_W-1:0] in_tag0,
    input  logic [TAG_W-1:0] in_tag1,
    output logic             in_ready,
    output logic [2:0]       out_valid,
    output logic [TAG_W-1:0] out_tag0,
    output logic [TAG_W-1:0] out_tag1,
    output logic [TAG_W-1:0] out_tag2
);
    logic [1:0]           dec_vld;
    logic [1:0]           dec_sub;
    logic [TAG_W-1:0]     dec_tag0;
    logic [TAG_W-1:0]     dec_tag1;
    logic                 go0;
    logic                 go1;
    unit_e                dst0;
    unit_e                dst1;
    logic [NUM_UNITS-1:0] unit_start;
    logic [NUM_UNITS-1:0] unit_free;
    logic [NUM_UNITS-1:0] unit_done;
    logic [TAG_W-1:0]     unit_tag [NUM_UNITS];
    logic [TAG_W-1:0]     lane_tag [NUM_UNITS];

    // The pair can be replaced once every held instruction leaves this cycle.
    assign in_ready = !dec_vld[0] || (go0 && (!dec_vld[1] || go1));

    // Decode holding register: load a new pair, or shift the younger forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_vld  <= '0;
            dec_sub  <= '0;
            dec_tag0 <= '0;
            dec_tag1 <= '0;
        end else if (in_ready) begin
            dec_vld  <= {in_valid[0] & in_valid[1], in_valid[0]};
            dec_sub  <= in_sub;
            dec_tag0 <= in_tag0;
            dec_tag1 <= in_tag1;
        end else if (go0) begin
            dec_vld    <= {1'b0, dec_vld[1]};
            dec_sub[0] <= dec_sub[1];
            dec_tag0   <= dec_tag1;
        end
    end

    exd_issue u_issue (
        .slot_vld  (dec_vld),
        .slot_sub  (dec_sub),
        .unit_free (unit_free),
        .go0       (go0),
        .go1       (go1),
        .dst0      (dst0),
        .dst1      (dst1)
    );

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        localparam unit_e ME  = unit_e'(g);
        localparam int    LAT = (g == 0) ? SUB_LAT : ADD_LAT;
        logic hit0;
        logic hit1;

        assign hit0          = go0 && (dst0 == ME);
        assign hit1          = go1 && (dst1 == ME);
        assign unit_start[g] = hit0 || hit1;

        exd_unit #(.LAT(LAT), .TAG_W(TAG_W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (unit_start[g]),
            .start_tag (hit0 ? dec_tag0 : dec_tag1),
            .free      (unit_free[g]),
            .done      (unit_done[g]),
            .tag       (unit_tag[g])
        );
    end

    exd_order #(.NUM(NUM_UNITS), .TAG_W(TAG_W)) u_order (
        .done    (unit_done),
        .tag_in  (unit_tag),
        .vld_out (out_valid),
        .tag_out (lane_tag)
    );

    assign out_tag0 = lane_tag[0];
    assign out_tag1 = lane_tag[1];
    assign out_tag2 = lane_tag[2];
endmodule

// File: rtl/exd_checker.sv
// Property checker for ex_dispatch, attached through bind below.
// Watches the decode register, the unit handshakes and the output lanes.
module exd_checker #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       in_valid,
    input logic             in_ready,
    input logic [2:0]       out_valid,
    input logic [2:0]       unit_start,
    input logic [2:0]       unit_free,
    input logic [2:0]       unit_done,
    input logic [1:0]       dec_vld,
    input logic             dec_sub0,
    input logic [TAG_W-1:0] dec_tag0,
    input logic [TAG_W-1:0] dec_tag1,
    input logic             go0
);
    // R1: one reset edge leaves the block idle and ready.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (in_ready && out_valid == 3'b000 && unit_free == 3'b111));

    // R2: the younger lane is never offered alone.
    a_r2_pair_packed: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid[1] |-> in_valid[0]);

    // R4: a held subtraction that issues starts the subtracter.
    a_r4_sub_route: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld[0] && dec_sub0 && go0) |-> unit_start[0]);

    // R5: no unit is started while it is still busy.
    a_r5_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_start & ~unit_free) == 3'b000);

    // R6: an older instruction that cannot issue stays unchanged.
    a_r6_hold_older: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld[0] && !go0) |=> (dec_vld[0] && $stable(dec_tag0) && $stable(dec_sub0)));

    // R7: a younger instruction waits while the older one is stuck.
    a_r7_young_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld[1] && !go0) |=> (dec_vld[1] && $stable(dec_tag1)));

    // R9: every finishing unit gets exactly one lane.
    a_r9_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) == $countones(unit_done));

    // R9: lanes are filled from lane 0 without gaps.
    a_r9_lane_packed: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[2] |-> out_valid[1]) and (out_valid[1] |-> out_valid[0]));
endmodule

bind ex_dispatch exd_checker #(.TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .unit_start (unit_start),
    .unit_free  (unit_free),
    .unit_done  (unit_done),
    .dec_vld    (dec_vld),
    .dec_sub0   (dec_sub[0]),
    .dec_tag0   (dec_tag0),
    .dec_tag1   (dec_tag1),
    .go0        (go0)
);

// File: tb/sim_ex_dispatch.sv
// Scoreboard bench: the driver pushes (cycle, tag) expectations derived from
// the requirements, and a monitor pops and compares them lane by lane.
module sim_ex_dispatch;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    in_valid;
    logic [1:0]    in_sub;
    logic [TW-1:0] in_tag0;
    logic [TW-1:0] in_tag1;
    logic          in_ready;
    logic [2:0]    out_valid;
    logic [TW-1:0] out_tag0;
    logic [TW-1:0] out_tag1;
    logic [TW-1:0] out_tag2;

    int cyc = 0;
    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        int            when;
        logic [TW-1:0] tag;
        string         req;
    } exp_t;

    exp_t exq[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    ex_dispatch #(.TAG_W(TW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sub    (in_sub),
        .in_tag0   (in_tag0),
        .in_tag1   (in_tag1),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_tag0  (out_tag0),
        .out_tag1  (out_tag1),
        .out_tag2  (out_tag2)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int when, input logic [TW-1:0] tag, input string req);
        exp_t e;
        e.when = when;
        e.tag  = tag;
        e.req  = req;
        exq.push_back(e);
    endtask

    // Offer a pair at a falling edge once in_ready is seen; n is the offer cycle.
    task automatic send(input logic [1:0] v, input logic [1:0] s,
                        input logic [TW-1:0] a, input logic [TW-1:0] b, output int n);
        while (!in_ready) @(negedge clk);
        in_valid = v;
        in_sub   = s;
        in_tag0  = a;
        in_tag1  = b;
        n        = cyc;
        @(negedge clk);
        in_valid = 2'b00;
    endtask

    task automatic drain();
        while (exq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [TW-1:0] lane_tag(input int k);
        case (k)
            0:       return out_tag0;
            1:       return out_tag1;
            default: return out_tag2;
        endcase
    endfunction

    // Monitor: compare each valid lane with the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            for (int k = 0; k < 3; k++) begin
                if (out_valid[k]) begin
                    if (k > 0 && !out_valid[k-1])
                        check(1'b0, "R9", "lane gap", k, k - 1);
                    if (exq.size() == 0) begin
                        check(1'b0, "R9", "unexpected tag", int'(lane_tag(k)), -1);
                    end else begin
                        exp_t e;
                        e = exq.pop_front();
                        check(e.when == cyc, e.req, "completion cycle", cyc, e.when);
                        check(lane_tag(k) == e.tag, e.req, "lane tag", int'(lane_tag(k)), int'(e.tag));
                    end
                end
            end
            while (exq.size() != 0 && exq[0].when <= cyc) begin
                exp_t e;
                e = exq.pop_front();
                check(1'b0, e.req, "missing completion", -1, int'(e.tag));
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        int n2;
        rst_n    = 1'b0;
        in_valid = 2'b00;
        in_sub   = 2'b00;
        in_tag0  = '0;
        in_tag1  = '0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 3'b000, "R1", "out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: lone add completes three cycles after offer
        send(2'b01, 2'b00, 4'd1, 4'd0, n);
        expect_at(n + 3, 4'd1, "R3");
        drain();

        // R8: add pair issues together, older on lane 0
        send(2'b11, 2'b00, 4'd2, 4'd3, n);
        expect_at(n + 3, 4'd2, "R8");
        expect_at(n + 3, 4'd3, "R8");
        drain();

        // R4: subtract and add of one pair issue together, finish apart
        send(2'b11, 2'b01, 4'd4, 4'd5, n);
        expect_at(n + 3, 4'd5, "R3");
        expect_at(n + 4, 4'd4, "R4");
        drain();

        // R5: two subtractions serialize on the one subtracter
        send(2'b11, 2'b11, 4'd6, 4'd7, n);
        check(in_ready == 1'b0, "R6", "in_ready while younger waits", int'(in_ready), 0);
        expect_at(n + 4, 4'd6, "R5");
        expect_at(n + 8, 4'd7, "R5");
        drain();

        // R9: three completions in one cycle, subtraction oldest
        send(2'b01, 2'b01, 4'd8, 4'd0, n);
        send(2'b11, 2'b00, 4'd9, 4'd10, n2);
        check(n2 == n + 1, "R9", "pair accepted next cycle", n2, n + 1);
        expect_at(n + 4, 4'd8, "R9");
        expect_at(n + 4, 4'd9, "R9");
        expect_at(n + 4, 4'd10, "R9");
        drain();

        // R5, R6: second add pair stalls until the adders free up
        send(2'b11, 2'b00, 4'd11, 4'd12, n);
        send(2'b11, 2'b00, 4'd13, 4'd14, n2);
        expect_at(n + 3, 4'd11, "R5");
        expect_at(n + 3, 4'd12, "R5");
        expect_at(n + 6, 4'd13, "R5");
        expect_at(n + 6, 4'd14, "R5");
        check(in_ready == 1'b0, "R6", "in_ready while adders busy", int'(in_ready), 0);
        @(negedge clk);
        check(in_ready == 1'b0, "R6", "in_ready still stalled", int'(in_ready), 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R6", "in_ready once pair issues", int'(in_ready), 1);
        drain();

        // R7: younger add waits behind an older stalled subtraction
        send(2'b01, 2'b01, 4'd15, 4'd0, n);
        send(2'b11, 2'b01, 4'd1, 4'd2, n2);
        expect_at(n + 4, 4'd15, "R4");
        expect_at(n + 7, 4'd2, "R7");
        expect_at(n + 8, 4'd1, "R7");
        drain();

        // R1: reset while a subtraction is about to issue drops it
        send(2'b01, 2'b01, 4'd3, 4'd0, n);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            check(out_valid == 3'b000, "R1", "no completion after reset", int'(out_valid), 0);
            check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
            @(negedge clk);
        end

        // R3: block works normally after the mid-run reset
        send(2'b01, 2'b00, 4'd5, 4'd0, n);
        expect_at(n + 3, 4'd5, "R3");
        drain();

        check(exq.size() == 0, "R9", "scoreboard empty at end", exq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule